// File: doc/BRIEF.md
# Processor Status Register

This block holds the processor status word: the three ALU flags (carry, half carry between nibbles, zero), the two reset-cause bits (watchdog timeout and power-down) and the data-memory bank select bits. Three sources can update it in a single cycle. One is an instruction that names the register as its destination. Another is the ALU reporting new flag values. The third is a set of reset, sleep and watchdog events.

An instruction that writes this register and is also marked as one that updates flags cannot put its data into the three flag bits. Those bits take the ALU result instead, for the flags the ALU enables, and keep their old value otherwise. Instructions that update no flags, such as single-bit set and clear, nibble swap and moves from the working register, write every writable bit directly. The timeout and power-down bits change only through events. A register write never reaches them.

The bit layout is fixed: carry at bit 0, half carry at bit 1, zero at bit 2, power-down at bit 3, timeout at bit 4, and the bank select bits from bit 5 upward. Bit 5 picks between the two lower data banks.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low the register reads 0x18 (timeout and power-down at 1, every other bit 0).
- R2: A write with `instr_sets_flags` low loads bits 2:0 (carry bit 0, half carry bit 1, zero bit 2) from `wr_data` on the next clock, except for any flag whose `flag_upd_en` bit is set.
- R3: A write with `instr_sets_flags` high ignores `wr_data[2:0]`. Each flag with its `flag_upd_en` bit set takes `flag_upd_val`, and the others keep their value. Writing 0 with only the zero flag updated to 1 gives 000u u1uu.
- R4: With no write, each flag whose `flag_upd_en` bit (bit 0 carry, 1 half carry, 2 zero) is set loads the matching `flag_upd_val` bit on the next clock, and the other flags hold.
- R5: No write can change timeout (bit 4) or power-down (bit 3). In a cycle with no event they hold.
- R6: `evt_wdt_timeout` clears timeout on the next clock and leaves power-down alone.
- R7: `evt_sleep` clears power-down on the next clock and leaves timeout alone.
- R8: `evt_wdt_clear` sets both timeout and power-down. If `evt_wdt_timeout` or `evt_sleep` arrives in the same cycle, the clearing event wins for its own bit.
- R9: Any write loads the bank bits (bits W-1:5) from `wr_data`, whether or not `instr_sets_flags` is high. Without a write they hold.
- R10: A cycle with no write, no flag update and no event leaves the whole register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register-file write to the status register |
| wr_data | input | W | Write data (W = 5 + NBANK) |
| instr_sets_flags | input | 1 | The current instruction updates the ALU flags |
| flag_upd_en | input | 3 | Per-flag update enable from the ALU (0 carry, 1 half carry, 2 zero) |
| flag_upd_val | input | 3 | Flag values from the ALU, same bit order |
| evt_wdt_timeout | input | 1 | Watchdog expired |
| evt_sleep | input | 1 | Sleep entered |
| evt_wdt_clear | input | 1 | Watchdog-clear instruction executed |
| status_q | output | W | Current register value |

## Verification
The bench uses the default of three bank select bits, which gives the full 8-bit layout. That makes the upper three cleared in the clear-register case visible as a whole field. Random writes, flag updates and events run for several hundred cycles. They cover every write/flag combination and the event collisions in which a watchdog clear meets a timeout or a sleep in the same cycle.

// File: rtl/status_pkg.sv
package status_pkg;
    localparam int NFLAG      = 3;
    localparam int POS_C      = 0;
    localparam int POS_DC     = 1;
    localparam int POS_Z      = 2;
    localparam int POS_PD     = 3;
    localparam int POS_TO     = 4;
    localparam int POS_BANK   = 5;

    typedef struct packed {
        logic             to;
        logic             pd;
        logic [NFLAG-1:0] flags;
    } stat_core_t;
endpackage

// File: rtl/stat_flag_merge.sv
module stat_flag_merge #(
    parameter int NF = 3
) (
    input  logic [NF-1:0] flags_q,
    input  logic          wr_en,
    input  logic [NF-1:0] wr_flags,
    input  logic          instr_sets_flags,
    input  logic [NF-1:0] upd_en,
    input  logic [NF-1:0] upd_val,
    output logic [NF-1:0] flags_d
);
    logic data_reaches_flags;
    assign data_reaches_flags = wr_en && !instr_sets_flags;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_comb begin
            if (upd_en[i]) begin
                flags_d[i] = upd_val[i];
            end else if (data_reaches_flags) begin
                flags_d[i] = wr_flags[i];
            end else begin
                flags_d[i] = flags_q[i];
            end
        end
    end
endmodule

// File: rtl/stat_pwr_bits.sv
module stat_pwr_bits (
    input  logic to_q,
    input  logic pd_q,
    input  logic evt_wdt_timeout,
    input  logic evt_sleep,
    input  logic evt_wdt_clear,
    output logic to_d,
    output logic pd_d
);
    always_comb begin
        to_d = to_q;
        pd_d = pd_q;
        if (evt_wdt_clear) begin
            to_d = 1'b1;
            pd_d = 1'b1;
        end
        if (evt_wdt_timeout) to_d = 1'b0;
        if (evt_sleep)       pd_d = 1'b0;
    end
endmodule

// File: rtl/stat_bank_merge.sv
module stat_bank_merge #(
    parameter int NB = 3
) (
    input  logic [NB-1:0] bank_q,
    input  logic          wr_en,
    input  logic [NB-1:0] wr_bank,
    output logic [NB-1:0] bank_d
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_d[b] = wr_en ? wr_bank[b] : bank_q[b];
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
    parameter int NBANK = 3,
    localparam int W    = status_pkg::POS_BANK + NBANK
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         instr_sets_flags,
    input  logic [status_pkg::NFLAG-1:0] flag_upd_en,
    input  logic [status_pkg::NFLAG-1:0] flag_upd_val,
    input  logic                         evt_wdt_timeout,
    input  logic                         evt_sleep,
    input  logic                         evt_wdt_clear,
    output logic [W-1:0]                 status_q
);
    import status_pkg::*;

    typedef struct packed {
        logic [NBANK-1:0] bank;
        stat_core_t       core;
    } stat_t;

    localparam stat_t RST_VAL = '{bank: '0, core: '{to: 1'b1, pd: 1'b1, flags: '0}};

    stat_t            st_d, st_q;
    logic [NFLAG-1:0] flags_d;
    logic             to_d, pd_d;
    logic [NBANK-1:0] bank_d;

    stat_flag_merge #(.NF(NFLAG)) u_flags (
        .flags_q          (st_q.core.flags),
        .wr_en            (wr_en),
        .wr_flags         (wr_data[POS_Z:POS_C]),
        .instr_sets_flags (instr_sets_flags),
        .upd_en           (flag_upd_en),
        .upd_val          (flag_upd_val),
        .flags_d          (flags_d)
    );

    stat_pwr_bits u_pwr (
        .to_q            (st_q.core.to),
        .pd_q            (st_q.core.pd),
        .evt_wdt_timeout (evt_wdt_timeout),
        .evt_sleep       (evt_sleep),
        .evt_wdt_clear   (evt_wdt_clear),
        .to_d            (to_d),
        .pd_d            (pd_d)
    );

    stat_bank_merge #(.NB(NBANK)) u_bank (
        .bank_q  (st_q.bank),
        .wr_en   (wr_en),
        .wr_bank (wr_data[W-1:POS_BANK]),
        .bank_d  (bank_d)
    );

    always_comb begin
        st_d            = st_q;
        st_d.core.flags = flags_d;
        st_d.core.to    = to_d;
        st_d.core.pd    = pd_d;
        st_d.bank       = bank_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign status_q = st_q;

    logic any_evt;
    assign any_evt = evt_wdt_timeout || evt_sleep || evt_wdt_clear;

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (status_q == W'(8'h18)));

    assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !instr_sets_flags && flag_upd_en == '0)
        |=> status_q[POS_Z:POS_C] == $past(wr_data[POS_Z:POS_C]));

    assert_flag_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && instr_sets_flags && flag_upd_en == '0)
        |=> $stable(status_q[POS_Z:POS_C]));

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
        assert_flag_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
            flag_upd_en[i] |=> status_q[i] == $past(flag_upd_val[i]));
    end

    assert_pwr_immune_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> $stable(status_q[POS_TO:POS_PD]));

    assert_timeout_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wdt_timeout |=> !status_q[POS_TO]);

    assert_sleep_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sleep |=> !status_q[POS_PD]);

    assert_wdt_clear_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt_clear && !evt_wdt_timeout && !evt_sleep)
        |=> (status_q[POS_TO] && status_q[POS_PD]));

    assert_bank_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status_q[W-1:POS_BANK] == $past(wr_data[W-1:POS_BANK]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && flag_upd_en == '0 && !any_evt) |=> $stable(status_q));
endmodule

// File: tb/tb_cpu_status_reg.sv
module tb_cpu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       instr_sets_flags = 1'b0;
    logic [2:0] flag_upd_en = '0;
    logic [2:0] flag_upd_val = '0;
    logic       evt_wdt_timeout = 1'b0;
    logic       evt_sleep = 1'b0;
    logic       evt_wdt_clear = 1'b0;
    logic [7:0] status_q;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] expv;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpu_status_reg #(.NBANK(3)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .instr_sets_flags(instr_sets_flags), .flag_upd_en(flag_upd_en),
        .flag_upd_val(flag_upd_val), .evt_wdt_timeout(evt_wdt_timeout),
        .evt_sleep(evt_sleep), .evt_wdt_clear(evt_wdt_clear), .status_q(status_q)
    );

    function automatic logic [7:0] model(input logic [7:0] cur);
        logic [7:0] n;
        n = cur;
        if (wr_en) begin
            n[7:5] = wr_data[7:5];
            if (!instr_sets_flags) n[2:0] = wr_data[2:0];
        end
        for (int i = 0; i < 3; i++) if (flag_upd_en[i]) n[i] = flag_upd_val[i];
        if (evt_wdt_clear) begin n[4] = 1'b1; n[3] = 1'b1; end
        if (evt_wdt_timeout) n[4] = 1'b0;
        if (evt_sleep) n[3] = 1'b0;
        return n;
    endfunction

    task automatic check(input string tag);
        n_run++;
        if (status_q !== expv) begin
            n_fail++;
            $display("FAIL %s: status actual %02h expected %02h", tag, status_q, expv);
        end
    endtask

    task automatic drive(input logic we, input logic [7:0] wd, input logic aff,
                         input logic [2:0] fen, input logic [2:0] fv,
                         input logic to_e, input logic sl_e, input logic clr_e);
        wr_en = we; wr_data = wd; instr_sets_flags = aff;
        flag_upd_en = fen; flag_upd_val = fv;
        evt_wdt_timeout = to_e; evt_sleep = sl_e; evt_wdt_clear = clr_e;
    endtask

    task automatic step(input string tag);
        expv = model(expv);
        @(posedge clk);
        @(negedge clk);
        check(tag);
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expv = 8'h18;
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        drive(1, 8'hFF, 0, 3'b000, 3'b000, 0, 0, 0); step("R2 R5 R9");
        drive(1, 8'h1A, 0, 3'b000, 3'b000, 0, 0, 0); step("R2");
        drive(1, 8'h00, 1, 3'b100, 3'b100, 0, 0, 0); step("R3 clear");
        drive(1, 8'hE7, 1, 3'b000, 3'b000, 0, 0, 0); step("R3 R9");
        drive(1, 8'h07, 1, 3'b001, 3'b000, 0, 0, 0); step("R3");
        drive(0, 8'h00, 0, 3'b011, 3'b011, 0, 0, 0); step("R4");
        drive(0, 8'h00, 0, 3'b110, 3'b000, 0, 0, 0); step("R4");
        drive(1, 8'h05, 0, 3'b010, 3'b010, 0, 0, 0); step("R2 R4");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 0, 0); step("R10");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 1, 0, 0); step("R6");
        drive(1, 8'h10, 0, 3'b000, 3'b000, 0, 0, 0); step("R5");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 0, 1); step("R8");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 1, 0); step("R7");
        drive(1, 8'h08, 0, 3'b000, 3'b000, 0, 0, 0); step("R5");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 1, 0, 1); step("R8 timeout wins");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 1, 1); step("R8 sleep wins");
        drive(0, 8'h00, 0, 3'b000, 3'b000, 0, 0, 1); step("R8");
        drive(1, 8'h40, 1, 3'b000, 3'b000, 0, 0, 0); step("R9");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0], r[15:8], r[1], r[4:2], r[7:5],
                  (r[19:16] == 4'h0), (r[23:20] == 4'h0), (r[27:24] == 4'h0));
            step("R2-mix R3 R4 R5 R6 R7 R8 R9 R10");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule